// File: doc/BRIEF.md
# Two-Stage System Watchdog Timer

A countdown watchdog for a system controller, programmed over a small byte-enabled 16-bit register bus. A prescaler divides the input clock into a slow tick, and the counter steps down by one on each tick. Software keeps the system alive by writing to the reload register, which puts the stored initial value back into the counter. It can also halt the counter, change the initial value and read the current count.

When the counter is at zero on a tick, it reloads and the block raises a timeout status bit together with a one-cycle interrupt pulse. If the counter runs out again before software clears that status, the block sets a second-timeout flag and a boot flag. It then asserts a sticky system reset request, unless the no-reboot inhibit bit is set. All status flags are write-one-to-clear.

The register bus has a valid strobe and a write flag. It has no back-pressure: every access is accepted in the cycle it is presented. A read answers on the next cycle with a one-cycle `bus_rvalid`. Interrupt and reset outputs are plain level signals.

Top module: `sys_wdog`

## Requirements
- R1: After reset the halt bit (control word 0x08, bit 11) and the no-reboot bit (0x08, bit 0) are 1, the count and the stored initial value equal DEF_INIT, all status bits are 0 and `reset_req` is low.
- R2: While the halt bit is 0, the count decrements by one every TICK_DIV clock cycles. While the halt bit is 1, the count does not change.
- R3: A write to word 0x00 with byte lane 0 enabled loads the stored initial value into the count and restarts the prescaler. A read of 0x00 returns the count in bits INIT_W-1:0.
- R4: In the 10-bit variant the initial value sits in bits 9:0 of word 0x12 and is written only when both byte lanes are enabled. In the 6-bit variant it sits in bits 13:8 of word 0x00, byte lane 1. A written value of 0 to 3 leaves the stored value unchanged.
- R5: When the count is 0 on a tick and the timeout flag (0x04, bit 3) is clear, the flag sets, `timeout_irq` pulses high for exactly one cycle and the count reloads.
- R6: When the count is 0 on a tick and the timeout flag is already set, the second-timeout flag (0x06, bit 1) and the boot flag (0x06, bit 2) set. `reset_req` rises if the no-reboot bit is 0 and then stays high until the block's reset.
- R7: While the no-reboot bit is 1, an expiry never raises `reset_req`. The bit reads back from 0x08, bit 0, and is written through byte lane 0.
- R8: Writing 1 to a status bit position, with byte lane 0 enabled, clears that bit. Writing 0 leaves it unchanged. A set caused by an expiry in the same cycle takes precedence over the clear.
- R9: A read strobe in one cycle gives `bus_rvalid` high for exactly the next cycle, with `bus_rdata` holding the register value from the strobe cycle. Unmapped addresses read as 0.
- R10: With no reload, consecutive expiries are (initial value + 1) x TICK_DIV cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the 16-bit word |
| bus_be | input | 2 | Byte lane enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| timeout_irq | output | 1 | One-cycle pulse on the first expiry |
| reset_req | output | 1 | Sticky system reset request |

## Verification
The bench drives the block through several patterns and compares its outputs on every clock with a behavioural model. First it sits halted, which shows that the halt bit freezes the count. Next it writes initial values of 0 to 3 and then legal values, which separates the rejection of small values from ordinary storage. It then lets the counter run free with the no-reboot bit set and then cleared, which separates the first-stage interrupt from the second-stage flags and from the reset request. Periodic reloads confirm that keepalive writes prevent any expiry. Measuring the gap between two interrupts, with the status cleared in between, pins down the expiry period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int AW = 5;
  localparam logic [AW-1:0] A_RELOAD = 5'h00;
  localparam logic [AW-1:0] A_STS1   = 5'h04;
  localparam logic [AW-1:0] A_STS2   = 5'h06;
  localparam logic [AW-1:0] A_CTRL   = 5'h08;
  localparam logic [AW-1:0] A_INIT   = 5'h12;
  localparam int B_TO    = 3;
  localparam int B_SEC   = 1;
  localparam int B_BOOT  = 2;
  localparam int B_HALT  = 11;
  localparam int B_NOREB = 0;
  localparam int MIN_INIT = 4;
endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int TICK_DIV = 75_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre;

  assign tick = run && (pre == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || restart || tick) pre <= '0;
    else                                   pre <= pre + 1'b1;
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int INIT_W   = 10,
  parameter int DEF_INIT = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt,
  input  logic              reload,
  input  logic              tick,
  input  logic [INIT_W-1:0] init,
  output logic [INIT_W-1:0] cnt,
  output logic              expire
);
  assign expire = tick && !reload && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= INIT_W'(DEF_INIT);
    else if (reload) cnt <= init;
    else if (tick)   cnt <= (cnt == '0) ? init : cnt - 1'b1;
  end

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !reload) |=> $stable(cnt)); // R2
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !reload && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R2
  AST_INIT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    init >= INIT_W'(wdog_pkg::MIN_INIT)); // R4
endmodule

// File: rtl/wdog_csr.sv
module wdog_csr
  import wdog_pkg::*;
#(
  parameter int INIT_W   = 10,
  parameter int DEF_INIT = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [AW-1:0]     bus_addr,
  input  logic [1:0]        bus_be,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [INIT_W-1:0] cnt,
  input  logic              expire,
  output logic              halt,
  output logic              reload,
  output logic [INIT_W-1:0] init,
  output logic              timeout_irq,
  output logic              reset_req
);
  localparam bit NARROW = (INIT_W <= 8);

  logic wr, rd;
  logic sts_to, sts_sec, sts_boot, noreboot;
  logic init_we;
  logic [INIT_W-1:0] init_wval;
  logic [15:0] cnt_word, init_word, rmux;

  assign wr     = bus_valid && bus_write;
  assign rd     = bus_valid && !bus_write;
  assign reload = wr && (bus_addr == A_RELOAD) && bus_be[0];

  generate
    if (NARROW) begin : g_narrow
      assign init_we   = wr && (bus_addr == A_RELOAD) && bus_be[1];
      assign init_wval = bus_wdata[8 +: INIT_W];
      assign cnt_word  = {{(8-INIT_W){1'b0}}, init, {(8-INIT_W){1'b0}}, cnt};
      assign init_word = 16'h0000;
    end else begin : g_wide
      assign init_we   = wr && (bus_addr == A_INIT) && (bus_be == 2'b11);
      assign init_wval = bus_wdata[INIT_W-1:0];
      assign cnt_word  = {{(16-INIT_W){1'b0}}, cnt};
      assign init_word = {{(16-INIT_W){1'b0}}, init};
    end
  endgenerate

  always_comb begin
    rmux = 16'h0000;
    case (bus_addr)
      A_RELOAD: rmux = cnt_word;
      A_STS1:   rmux[B_TO] = sts_to;
      A_STS2:   begin rmux[B_SEC] = sts_sec; rmux[B_BOOT] = sts_boot; end
      A_CTRL:   begin rmux[B_HALT] = halt; rmux[B_NOREB] = noreboot; end
      default:  if (!NARROW && bus_addr == A_INIT) rmux = init_word;
    endcase
  end

  logic clr_to, clr_sec, clr_boot, first_exp, second_exp;
  assign clr_to     = wr && bus_be[0] && (bus_addr == A_STS1) && bus_wdata[B_TO];
  assign clr_sec    = wr && bus_be[0] && (bus_addr == A_STS2) && bus_wdata[B_SEC];
  assign clr_boot   = wr && bus_be[0] && (bus_addr == A_STS2) && bus_wdata[B_BOOT];
  assign first_exp  = expire && !sts_to;
  assign second_exp = expire && sts_to;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init        <= INIT_W'(DEF_INIT);
      halt        <= 1'b1;
      noreboot    <= 1'b1;
      sts_to      <= 1'b0;
      sts_sec     <= 1'b0;
      sts_boot    <= 1'b0;
      timeout_irq <= 1'b0;
      reset_req   <= 1'b0;
      bus_rvalid  <= 1'b0;
      bus_rdata   <= 16'h0000;
    end else begin
      bus_rvalid  <= rd;
      if (rd) bus_rdata <= rmux;
      timeout_irq <= first_exp;
      sts_to      <= first_exp  || (sts_to   && !clr_to);
      sts_sec     <= second_exp || (sts_sec  && !clr_sec);
      sts_boot    <= second_exp || (sts_boot && !clr_boot);
      if (second_exp && !noreboot) reset_req <= 1'b1;
      if (init_we && (init_wval >= INIT_W'(MIN_INIT))) init <= init_wval;
      if (wr && bus_addr == A_CTRL) begin
        if (bus_be[1]) halt     <= bus_wdata[B_HALT];
        if (bus_be[0]) noreboot <= bus_wdata[B_NOREB];
      end
    end
  end

  AST_IRQ_FIRST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_irq |-> (sts_to && !$past(sts_to))); // R5
  AST_RESET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> reset_req); // R6
  AST_NOREBOOT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> !$past(noreboot)); // R7
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(rd)); // R9
endmodule

// File: rtl/sys_wdog.sv
module sys_wdog #(
  parameter int INIT_W   = 10,
  parameter int DEF_INIT = 50,
  parameter int TICK_DIV = 75_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [4:0]  bus_addr,
  input  logic [1:0]  bus_be,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        bus_rvalid,
  output logic        timeout_irq,
  output logic        reset_req
);
  logic halt, reload, tick, expire;
  logic [INIT_W-1:0] init, cnt;

  wdog_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(!halt), .restart(reload), .tick(tick)
  );

  wdog_count #(.INIT_W(INIT_W), .DEF_INIT(DEF_INIT)) u_count (
    .clk(clk), .rst_n(rst_n), .halt(halt), .reload(reload), .tick(tick),
    .init(init), .cnt(cnt), .expire(expire)
  );

  wdog_csr #(.INIT_W(INIT_W), .DEF_INIT(DEF_INIT)) u_csr (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .cnt(cnt),
    .expire(expire), .halt(halt), .reload(reload), .init(init),
    .timeout_irq(timeout_irq), .reset_req(reset_req)
  );
endmodule

// File: tb/sys_wdog_tb.sv
module sys_wdog_tb;
  localparam int DIV  = 4;
  localparam int DEF  = 50;

  logic clk = 0, rst_n = 0;
  logic bv = 0, bw = 0;
  logic [4:0] ba = 0;
  logic [1:0] be = 0;
  logic [15:0] wd = 0;
  logic [15:0] rdata;
  logic rvalid, irq, rreq;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sys_wdog #(.INIT_W(10), .DEF_INIT(DEF), .TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bv), .bus_write(bw), .bus_addr(ba),
    .bus_be(be), .bus_wdata(wd), .bus_rdata(rdata), .bus_rvalid(rvalid),
    .timeout_irq(irq), .reset_req(rreq)
  );

  // behavioural reference
  int m_pre, m_cnt, m_init;
  bit m_halt, m_nr, m_to, m_sec, m_boot, m_rst, m_irq, m_rv;
  int m_rd;

  function automatic int mread(int a);
    case (a)
      0:  return m_cnt;
      4:  return m_to ? 8 : 0;
      6:  return (m_sec ? 2 : 0) + (m_boot ? 4 : 0);
      8:  return (m_halt ? 16'h0800 : 0) + (m_nr ? 1 : 0);
      18: return m_init;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_pre = 0; m_cnt = DEF; m_init = DEF; m_halt = 1; m_nr = 1;
      m_to = 0; m_sec = 0; m_boot = 0; m_rst = 0; m_irq = 0; m_rv = 0; m_rd = 0;
    end else begin
      bit wr, rl, tk, ex, old_to, old_nr;
      wr = bv && bw;
      rl = wr && ba == 0 && be[0];
      tk = !m_halt && m_pre == DIV - 1;
      ex = tk && !rl && m_cnt == 0;
      old_to = m_to; old_nr = m_nr;
      m_rv = bv && !bw;
      if (m_rv) m_rd = mread(int'(ba));
      if (rl) m_cnt = m_init;
      else if (tk) m_cnt = (m_cnt == 0) ? m_init : m_cnt - 1;
      m_pre = (m_halt || rl || tk) ? 0 : m_pre + 1;
      if (wr && be[0] && ba == 4 && wd[3]) m_to = 0;
      if (wr && be[0] && ba == 6 && wd[1]) m_sec = 0;
      if (wr && be[0] && ba == 6 && wd[2]) m_boot = 0;
      m_irq = 0;
      if (ex) begin
        if (!old_to) begin m_to = 1; m_irq = 1; end
        else begin m_sec = 1; m_boot = 1; if (!old_nr) m_rst = 1; end
      end
      if (wr && ba == 8) begin
        if (be[1]) m_halt = wd[11];
        if (be[0]) m_nr = wd[0];
      end
      if (wr && ba == 18 && be == 2'b11 && int'(wd[9:0]) >= 4) m_init = int'(wd[9:0]);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-clock comparison with the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 timeout_irq", int'(irq), int'(m_irq));
      chk("R6 reset_req", int'(rreq), int'(m_rst));
      chk("R9 rvalid", int'(rvalid), int'(m_rv));
      if (m_rv) chk("R9 rdata", int'(rdata), m_rd);
    end
  end

  task automatic wr_reg(int a, int b, int d);
    @(negedge clk);
    bv = 1; bw = 1; ba = 5'(a); be = 2'(b); wd = 16'(d);
    @(negedge clk);
    bv = 0; bw = 0; be = 0;
  endtask

  task automatic rd_reg(int a, output int v);
    @(negedge clk);
    bv = 1; bw = 0; ba = 5'(a);
    @(negedge clk);
    bv = 0;
    v = int'(rdata);
  endtask

  task automatic wait_irq(output int t);
    int n = 0;
    while (irq !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
    t = cyc;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    int v, t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 reset_req", int'(rreq), 0);
    rd_reg(0, v);  chk("R1 count", v, DEF);
    rd_reg(8, v);  chk("R1 ctrl", v, 16'h0801);
    rd_reg(4, v);  chk("R1 sts1", v, 0);
    rd_reg(6, v);  chk("R1 sts2", v, 0);
    rd_reg(18, v); chk("R1 init", v, DEF);
    // R2 halted counter frozen
    repeat (20) @(negedge clk);
    rd_reg(0, v);  chk("R2 halted count", v, DEF);
    // R4 small initial values rejected
    wr_reg(18, 3, 3); rd_reg(18, v); chk("R4 value 3 ignored", v, DEF);
    wr_reg(18, 3, 0); rd_reg(18, v); chk("R4 value 0 ignored", v, DEF);
    wr_reg(18, 1, 12); rd_reg(18, v); chk("R4 partial lanes ignored", v, DEF);
    wr_reg(18, 3, 4); rd_reg(18, v); chk("R4 value 4 kept", v, 4);
    wr_reg(18, 3, 12); rd_reg(18, v); chk("R4 value 12 kept", v, 12);
    // R3 reload
    wr_reg(0, 1, 0); rd_reg(0, v); chk("R3 reload count", v, 12);
    // R2 run, keep no-reboot set
    wr_reg(8, 2, 0);
    repeat (10) @(negedge clk);
    rd_reg(0, v); chk("R2 running count below init", int'(v < 12), 1);
    // R5 first expiry
    wait_irq(t1);
    chk("R5 irq seen", int'(irq), 1);
    @(negedge clk); chk("R5 irq one cycle", int'(irq), 0);
    rd_reg(4, v); chk("R5 timeout flag", v, 8);
    // R6/R7 second expiry blocked by no-reboot
    repeat (60) @(negedge clk);
    rd_reg(6, v); chk("R6 second flags", v, 6);
    chk("R7 no reset while inhibited", int'(rreq), 0);
    // R8 W1C
    wr_reg(6, 1, 2); rd_reg(6, v); chk("R8 clear sec only", v, 4);
    wr_reg(6, 1, 4); rd_reg(6, v); chk("R8 clear boot", v, 0);
    wr_reg(4, 1, 0); rd_reg(4, v); chk("R8 zero write keeps", v, 8);
    wr_reg(4, 1, 8); rd_reg(4, v); chk("R8 clear timeout", v, 0);
    // R10 period between expiries
    wait_irq(t1);
    wr_reg(4, 1, 8);
    wait_irq(t2);
    chk("R10 expiry period", t2 - t1, 13 * DIV);
    wr_reg(4, 1, 8);
    // R3 keepalive prevents expiry
    wr_reg(0, 1, 0);
    for (int k = 0; k < 10; k++) begin
      repeat (20) @(negedge clk);
      chk("R3 no irq under keepalive", int'(irq), 0);
      wr_reg(0, 1, 0);
    end
    rd_reg(4, v); chk("R3 no timeout under keepalive", v, 0);
    // R6/R7 clear no-reboot, let it fire twice
    wr_reg(8, 1, 0);
    rd_reg(8, v); chk("R7 no-reboot readback", v, 0);
    wait_irq(t1);
    repeat (70) @(negedge clk);
    chk("R6 reset request raised", int'(rreq), 1);
    wr_reg(6, 1, 6); wr_reg(4, 1, 8);
    repeat (30) @(negedge clk);
    chk("R6 reset request sticky", int'(rreq), 1);
    // R2 halt again
    wr_reg(8, 2, 16'h0800);
    rd_reg(0, v); t1 = v;
    repeat (30) @(negedge clk);
    rd_reg(0, v); chk("R2 halt freezes", v, t1);
    // R1 reset clears request
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    chk("R1 reset_req cleared", int'(rreq), 0);
    rd_reg(0, v); chk("R1 count after reset", v, DEF);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule